// File: doc/BRIEF.md
# NAND Flash Target Command Front-End

This block is the device-side control logic of an emulated NAND flash target. It samples the host's active-low write and read strobes and the command-latch and address-latch qualifiers, all on the block's own clock. From these it decodes command, address and write-data cycles. It keeps the column and row address registers and runs the command sequencer. It drives a ready/busy output, with read, program, erase and reset busy lengths set by parameters in clock cycles. It answers status and identification reads itself.

Page data is never stored inside the block. Write-data bytes go out through a page-buffer port at an auto-incrementing column, and read data comes back through the same port. Array transfers are announced on a start port that carries an operation kind and a row. An external model performs the transfer and reports pass or fail on a single input. The sequencer enforces the legal command order. While busy it accepts only status and reset. It cancels a pending program when any other command intervenes. It also keeps status mode sticky during a read session.

Top module: `nand_target_fe`

## Requirements
- R1: With `ce_n` low, a write-strobe rising edge (`we_n` 0 then 1 on consecutive clocks) is a command cycle when `cle`=1 and `ale`=0, an address cycle when `ale`=1 and `cle`=0, and a write-data cycle when both are 0. With `ce_n` high no cycle is decoded.
- R2: Each read-strobe falling edge (`re_n` 1 then 0, `ce_n` low) loads `dout` in that clock with the byte for the current column and advances the column by one.
- R3: While `ry_by` is 0, only 70h and FFh commands are acted on. Other commands, address cycles and data cycles are ignored. `ce_n` going high does not stop the busy countdown.
- R4: Command 00h, four address cycles (column low, column high, row low, row high) and then 30h pulse `arr_start` with `arr_kind`=0 and the row. `ry_by` then stays 0 for exactly T_READ cycles, after which reads return page-buffer bytes from the column.
- R5: In read-data mode, 05h, two column address cycles and E0h move the read column without a new array transfer.
- R6: After 80h and four address cycles, each data cycle writes `din` to `pb_addr`=column and advances the column. 10h then pulses `arr_start` with `arr_kind`=1 and holds `ry_by` at 0 for T_PROG cycles. The status fail bit then takes the value of `arr_fail`.
- R7: After 80h, any command other than 10h or FFh cancels the program and takes effect itself. A later 10h starts nothing.
- R8: 70h sets status mode, which holds until another command. When a read has been started, a following 00h with no address cycles resumes data output at the column that was latched when 30h arrived.
- R9: Command 90h with address 00h gives ID mode. Successive reads return 98h, F1h, 80h, 95h and 40h, and 00h after that.
- R10: In read and program setup, a fifth and any later address cycle leaves column and row unchanged.
- R11: FFh holds `ry_by` at 0 for T_RESET cycles and clears the fail and error bits. An FFh arriving during a reset busy period is ignored and does not lengthen it. An FFh arriving after ready starts a new reset.
- R12: With `wp_n` low, 10h and D0h start nothing. `wp_n` going low during program or erase busy ends busy on the next clock and sets the fail bit. Status bit 7 equals `wp_n`.
- R13: A code outside the command set, or a second-cycle command (30h, 10h, E0h, D0h) out of sequence, sets a sticky error bit that only FFh or `rst_n` clears. Status byte layout: bit 0 fail, bit 1 error, bits 5..2 zero, bit 6 ready, bit 7 `wp_n`.
- R14: Command 60h, two row address cycles and D0h pulse `arr_start` with `arr_kind`=2 and the row, then hold `ry_by` at 0 for T_ERASE cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Target select, active low |
| cle | input | 1 | Marks the byte as a command |
| ale | input | 1 | Marks the byte as an address |
| we_n | input | 1 | Write strobe, active low; the rising edge latches |
| re_n | input | 1 | Read strobe, active low; the falling edge advances |
| wp_n | input | 1 | Write protect, active low |
| din | input | 8 | Host byte for command, address and data cycles |
| dout | output | 8 | Byte returned on read strobes |
| ry_by | output | 1 | 1 when ready, 0 when busy |
| pb_addr | output | COL_W | Page-buffer column address |
| pb_we | output | 1 | Page-buffer write enable |
| pb_wdata | output | 8 | Page-buffer write data |
| pb_rdata | input | 8 | Page-buffer read data, combinational from pb_addr |
| arr_start | output | 1 | One-cycle pulse that starts an array transfer |
| arr_kind | output | 2 | 0 read, 1 program, 2 erase |
| arr_row | output | ROW_W | Row address for the transfer |
| arr_fail | input | 1 | Result of program/erase, sampled at the end of busy |

## Verification
The assertions assume that every input is synchronous to `clk`, and that each strobe level is held for at least one full clock so its edges are seen. They also assume that `cle` and `ale` are never high together during a write strobe, and that every busy length parameter is at least one. The bench changes all inputs only on falling clock edges. Each strobe level lasts a whole cycle, and each bus cycle raises exactly one qualifier or none, so the stimulus keeps within those assumptions. Busy lengths are measured by counting falling edges with `ry_by` low from the cycle the starting command is decoded. This covers the ignored second reset and the write-protect abort.

// File: rtl/nand_fe_pkg.sv
// Shared types and constants for the NAND target front-end.
// Assumes 8-bit host bus; command codes are fixed by the host protocol.
package nand_fe_pkg;

    typedef enum logic [3:0] {
        MD_IDLE, MD_RD_ADDR, MD_RD_DATA, MD_COLCHG, MD_STATUS,
        MD_ID_ADDR, MD_ID_DATA, MD_PG_LOAD, MD_ER_ADDR
    } mode_t;

    typedef enum logic [1:0] {
        OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_RESET = 2'd3
    } op_t;

    localparam logic [7:0] C_RD_SETUP  = 8'h00;
    localparam logic [7:0] C_RD_GO     = 8'h30;
    localparam logic [7:0] C_COL_SETUP = 8'h05;
    localparam logic [7:0] C_COL_GO    = 8'hE0;
    localparam logic [7:0] C_PG_SETUP  = 8'h80;
    localparam logic [7:0] C_PG_GO     = 8'h10;
    localparam logic [7:0] C_ER_SETUP  = 8'h60;
    localparam logic [7:0] C_ER_GO     = 8'hD0;
    localparam logic [7:0] C_IDENT     = 8'h90;
    localparam logic [7:0] C_STATUS    = 8'h70;
    localparam logic [7:0] C_RESET     = 8'hFF;

    localparam int ID_LEN = 5;

    // Identification byte for a given position; zero past the end.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h98;
            3'd1:    id_byte = 8'hF1;
            3'd2:    id_byte = 8'h80;
            3'd3:    id_byte = 8'h95;
            3'd4:    id_byte = 8'h40;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nand_fe_strobe.sv
// Strobe decoder: turns sampled write/read strobes into single-cycle
// command, address, write-data and read events.
// Assumes strobes are synchronous to clk and each level lasts >= 1 cycle.
module nand_fe_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic cle,
    input  logic ale,
    input  logic we_n,
    input  logic re_n,
    output logic cmd_v,
    output logic addr_v,
    output logic data_v,
    output logic rd_v
);
    logic we_q, re_q, we_rise;

    // Remember last strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    assign we_rise = we_n & ~we_q & ~ce_n;
    assign cmd_v   = we_rise &  cle & ~ale;
    assign addr_v  = we_rise &  ale & ~cle;
    assign data_v  = we_rise & ~cle & ~ale;
    assign rd_v    = ~re_n & re_q & ~ce_n;

    // A decoded bus cycle needs the write strobe low one clock earlier.
    assert_we_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v || addr_v || data_v) |-> $past(we_n) == 1'b0);

endmodule

// File: rtl/nand_fe_busy.sv
// Busy timer: loads a duration on start, counts down to zero, and can be
// cut short by abort. Assumes every loaded duration is at least 1.
module nand_fe_busy #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] dur,
    input  logic          abort,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Load, abort or count down the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (start)  cnt <= dur;
        else if (abort)  cnt <= '0;
        else if (busy)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1)) & ~start & ~abort;

    // Busy only ends through a natural finish or an abort.
    assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || abort));

endmodule

// File: rtl/nand_target_fe.sv
// NAND target command front-end: command sequencer, address registers,
// busy control, status and identification replies. Page data lives in an
// external buffer reached through pb_*; array transfers go out on arr_*.
// Assumes 9 <= COL_W <= 16, 9 <= ROW_W <= 16, all busy lengths >= 1.
module nand_target_fe #(
    parameter int COL_W   = 12,
    parameter int ROW_W   = 16,
    parameter int T_READ  = 64,
    parameter int T_PROG  = 256,
    parameter int T_ERASE = 1024,
    parameter int T_RESET = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic             wp_n,
    input  logic [7:0]       din,
    output logic [7:0]       dout,
    output logic             ry_by,
    output logic [COL_W-1:0] pb_addr,
    output logic             pb_we,
    output logic [7:0]       pb_wdata,
    input  logic [7:0]       pb_rdata,
    output logic             arr_start,
    output logic [1:0]       arr_kind,
    output logic [ROW_W-1:0] arr_row,
    input  logic             arr_fail
);
    import nand_fe_pkg::*;

    localparam int T_MAX1 = (T_READ > T_PROG) ? T_READ : T_PROG;
    localparam int T_MAX2 = (T_ERASE > T_RESET) ? T_ERASE : T_RESET;
    localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int TW     = $clog2(T_MAX + 1);

    logic cmd_v, addr_v, data_v, rd_v;
    logic busy, done, t_start, t_abort;
    logic [TW-1:0] t_dur;
    op_t  st_kind, kind;
    mode_t mode;
    logic [2:0] acnt, id_idx;
    logic [COL_W-1:0] col, rd_col;
    logic [ROW_W-1:0] row;
    logic rd_ctx, fail, err;
    logic [7:0] dout_q, status;

    nand_fe_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n),
        .cmd_v(cmd_v), .addr_v(addr_v), .data_v(data_v), .rd_v(rd_v)
    );

    nand_fe_busy #(.CW(TW)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(t_start), .dur(t_dur),
        .abort(t_abort), .busy(busy), .done(done)
    );

    // Decide whether this command starts a busy period, and of what kind.
    always_comb begin
        t_start = 1'b0;
        t_dur   = '0;
        st_kind = OP_READ;
        if (cmd_v) begin
            if (din == C_RESET) begin
                if (!(busy && kind == OP_RESET)) begin
                    t_start = 1'b1; t_dur = TW'(T_RESET); st_kind = OP_RESET;
                end
            end else if (!busy) begin
                if (din == C_RD_GO && mode == MD_RD_ADDR && acnt >= 3'd4) begin
                    t_start = 1'b1; t_dur = TW'(T_READ); st_kind = OP_READ;
                end else if (din == C_PG_GO && mode == MD_PG_LOAD && acnt >= 3'd4 && wp_n) begin
                    t_start = 1'b1; t_dur = TW'(T_PROG); st_kind = OP_PROG;
                end else if (din == C_ER_GO && mode == MD_ER_ADDR && acnt >= 3'd2 && wp_n) begin
                    t_start = 1'b1; t_dur = TW'(T_ERASE); st_kind = OP_ERASE;
                end
            end
        end
    end

    assign t_abort   = busy && (kind == OP_PROG || kind == OP_ERASE) && !wp_n && !t_start;
    assign arr_start = t_start && (st_kind != OP_RESET);
    assign arr_kind  = st_kind;
    assign arr_row   = row;
    assign ry_by     = ~busy;
    assign pb_addr   = col;
    assign pb_wdata  = din;
    assign pb_we     = data_v && !busy && (mode == MD_PG_LOAD);
    assign status    = {wp_n, ~busy, 4'b0000, err, fail};
    assign dout      = dout_q;

    // Command sequencer, address capture, result flags and read output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MD_IDLE; kind <= OP_READ; acnt <= '0; id_idx <= '0;
            col <= '0; rd_col <= '0; row <= '0;
            rd_ctx <= 1'b0; fail <= 1'b0; err <= 1'b0; dout_q <= '0;
        end else begin
            if (t_start) kind <= st_kind;
            if (t_start && (st_kind == OP_PROG || st_kind == OP_ERASE)) fail <= 1'b0;
            if (done && (kind == OP_PROG || kind == OP_ERASE)) fail <= arr_fail;
            if (t_abort) fail <= 1'b1;
            if (cmd_v) begin
                if (din == C_RESET) begin
                    if (t_start) begin
                        mode <= MD_IDLE; err <= 1'b0; fail <= 1'b0; rd_ctx <= 1'b0;
                    end
                end else if (din == C_STATUS) begin
                    mode <= MD_STATUS;
                end else if (!busy) begin
                    case (din)
                        C_RD_SETUP:
                            if (mode == MD_STATUS && rd_ctx) begin
                                mode <= MD_RD_DATA; col <= rd_col;
                            end else begin
                                mode <= MD_RD_ADDR; acnt <= '0;
                            end
                        C_RD_GO:
                            if (t_start) begin
                                mode <= MD_RD_DATA; rd_col <= col; rd_ctx <= 1'b1;
                            end else begin
                                mode <= MD_IDLE; err <= 1'b1;
                            end
                        C_COL_SETUP:
                            if (mode == MD_RD_DATA) begin
                                mode <= MD_COLCHG; acnt <= '0;
                            end else begin
                                mode <= MD_IDLE; err <= 1'b1;
                            end
                        C_COL_GO: begin
                            if (mode == MD_COLCHG && acnt >= 3'd2) mode <= MD_RD_DATA;
                            else begin mode <= MD_IDLE; err <= 1'b1; end
                        end
                        C_PG_SETUP: begin mode <= MD_PG_LOAD; acnt <= '0; rd_ctx <= 1'b0; end
                        C_PG_GO: begin
                            if (!(mode == MD_PG_LOAD && acnt >= 3'd4)) err <= 1'b1;
                            mode <= MD_IDLE;
                        end
                        C_ER_SETUP: begin mode <= MD_ER_ADDR; acnt <= '0; rd_ctx <= 1'b0; end
                        C_ER_GO: begin
                            if (!(mode == MD_ER_ADDR && acnt >= 3'd2)) err <= 1'b1;
                            mode <= MD_IDLE;
                        end
                        C_IDENT: begin mode <= MD_ID_ADDR; rd_ctx <= 1'b0; end
                        default: err <= 1'b1;
                    endcase
                end
            end else if (addr_v && !busy) begin
                if (acnt != 3'd7) acnt <= acnt + 1'b1;
                case (mode)
                    MD_RD_ADDR, MD_PG_LOAD, MD_COLCHG: begin
                        if (acnt == 3'd0) col[7:0] <= din;
                        if (acnt == 3'd1) col[COL_W-1:8] <= din[COL_W-9:0];
                        if (acnt == 3'd2 && mode != MD_COLCHG) row[7:0] <= din;
                        if (acnt == 3'd3 && mode != MD_COLCHG) row[ROW_W-1:8] <= din[ROW_W-9:0];
                    end
                    MD_ER_ADDR: begin
                        if (acnt == 3'd0) row[7:0] <= din;
                        if (acnt == 3'd1) row[ROW_W-1:8] <= din[ROW_W-9:0];
                    end
                    MD_ID_ADDR: begin
                        id_idx <= '0;
                        mode   <= (din == 8'h00) ? MD_ID_DATA : MD_IDLE;
                    end
                    default: ;
                endcase
            end else if (data_v && !busy && mode == MD_PG_LOAD) begin
                col <= col + 1'b1;
            end else if (rd_v) begin
                case (mode)
                    MD_STATUS: dout_q <= status;
                    MD_RD_DATA:
                        if (!busy) begin dout_q <= pb_rdata; col <= col + 1'b1; end
                    MD_ID_DATA:
                        if (!busy) begin
                            dout_q <= id_byte(id_idx);
                            if (id_idx < 3'(ID_LEN)) id_idx <= id_idx + 1'b1;
                        end
                    default: ;
                endcase
            end
        end
    end

    // Address and data cycles during busy leave the address registers alone.
    assert_busy_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (addr_v || data_v)) |=> ($stable(col) && $stable(row)));

    // An array start is always followed by a busy period.
    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !ry_by);

    // Status mode persists until a command arrives.
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STATUS && !cmd_v) |=> mode == MD_STATUS);

    // Dropping write protect during program/erase releases busy at once.
    assert_wp_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        t_abort |=> ry_by);

endmodule

// File: tb/test_nand_target_fe.sv
// Scoreboard bench: read tasks push expected bytes, a monitor pops and
// compares them against dout; other checks go through the same counters.
module test_nand_target_fe;
    localparam int TR = 6, TP = 10, TE = 14, TRS = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, pb_wdata, pb_rdata;
    logic ry_by, pb_we, arr_start, arr_fail = 1'b0;
    logic [11:0] pb_addr;
    logic [1:0]  arr_kind;
    logic [15:0] arr_row;

    logic [7:0] mem [0:4095];
    int n_cmp = 0, n_bad = 0, n_start = 0;
    logic [1:0]  last_kind;
    logic [15:0] last_row;
    logic [7:0]  exp_q [$];
    string       tag_q [$];
    logic [7:0]  got;
    event        rd_ev;

    always #4 clk = ~clk;

    nand_target_fe #(.COL_W(12), .ROW_W(16), .T_READ(TR), .T_PROG(TP),
                     .T_ERASE(TE), .T_RESET(TRS)) i_nand_target_fe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .din(din), .dout(dout),
        .ry_by(ry_by), .pb_addr(pb_addr), .pb_we(pb_we), .pb_wdata(pb_wdata),
        .pb_rdata(pb_rdata), .arr_start(arr_start), .arr_kind(arr_kind),
        .arr_row(arr_row), .arr_fail(arr_fail));

    // External page-buffer model.
    assign pb_rdata = mem[pb_addr];
    always @(posedge clk) if (pb_we) mem[pb_addr] <= pb_wdata;

    // Record array start requests.
    always @(posedge clk) if (rst_n && arr_start) begin
        n_start++; last_kind = arr_kind; last_row = arr_row;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each read byte against the queued expectation.
    initial forever begin
        @(rd_ev);
        if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", got, 0);
        else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check(got === e, t, got, e);
        end
    end

    task automatic bus_wr(input logic c, input logic a, input logic [7:0] b);
        cle = c; ale = a; din = b; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; ale = 1'b0;
    endtask
    task automatic cmd(input logic [7:0] b);  bus_wr(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b);  bus_wr(1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b);  bus_wr(1'b0, 1'b0, b); endtask

    task automatic rd_exp(input logic [7:0] e, input string req);
        exp_q.push_back(e); tag_q.push_back(req);
        re_n = 1'b0; @(negedge clk); re_n = 1'b1; got = dout; -> rd_ev;
        @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (ry_by == 1'b0 && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic addr4(input logic [7:0] c0, c1, r0, r1);
        adr(c0); adr(c1); adr(r0); adr(r1);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n, s0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(ry_by === 1'b1, "R11 reset ready", ry_by, 1);
        check(dout === 8'h00, "R11 reset dout", dout, 0);
        cmd(8'h70); rd_exp(8'hC0, "R11 status after reset");

        // Program with a fifth address cycle (R6, R10, R1)
        cmd(8'h80); addr4(8'h10, 8'h00, 8'h23, 8'h01); adr(8'h77);
        dat(8'hA1); dat(8'hB2); dat(8'hC3);
        check(mem[16] === 8'hA1, "R6 pb write col 10h", mem[16], 8'hA1);
        check(mem[17] === 8'hB2, "R1 data cycle col 11h", mem[17], 8'hB2);
        check(mem[18] === 8'hC3, "R10 fifth addr ignored col", mem[18], 8'hC3);
        s0 = n_start;
        cmd(8'h10); busy_len(n);
        check(n == TP, "R6 program busy length", n, TP);
        check(n_start == s0 + 1 && last_kind == 2'd1, "R6 program start kind", last_kind, 1);
        check(last_row === 16'h0123, "R10 fifth addr ignored row", last_row, 16'h0123);
        cmd(8'h70); rd_exp(8'hC0, "R6 status pass");

        // Page read (R4, R2)
        cmd(8'h00); addr4(8'h11, 8'h00, 8'h23, 8'h01);
        cmd(8'h30); busy_len(n);
        check(n == TR, "R4 read busy length", n, TR);
        check(last_kind == 2'd0 && last_row === 16'h0123, "R4 read start", last_row, 16'h0123);
        rd_exp(8'hB2, "R2 read col 11h"); rd_exp(8'hC3, "R2 read col 12h");

        // Column change (R5)
        cmd(8'h05); adr(8'h10); adr(8'h00); cmd(8'hE0);
        check(ry_by === 1'b1, "R5 no busy on column change", ry_by, 1);
        rd_exp(8'hA1, "R5 new col 10h"); rd_exp(8'hB2, "R5 new col 11h");

        // Sticky status and resume (R8), ce_n high blocks decode (R1)
        cmd(8'h70); rd_exp(8'hC0, "R8 status in read"); rd_exp(8'hC0, "R8 status sticky");
        cmd(8'h00); rd_exp(8'hB2, "R8 resume at start column");
        ce_n = 1'b1; cmd(8'h70); ce_n = 1'b0;
        rd_exp(8'hC3, "R1 ce_n high command ignored");

        // ID read (R9)
        cmd(8'h90); adr(8'h00);
        rd_exp(8'h98, "R9 id0"); rd_exp(8'hF1, "R9 id1"); rd_exp(8'h80, "R9 id2");
        rd_exp(8'h95, "R9 id3"); rd_exp(8'h40, "R9 id4"); rd_exp(8'h00, "R9 past end");

        // Unknown and out-of-sequence commands (R13)
        cmd(8'h55); cmd(8'h70); rd_exp(8'hC2, "R13 error bit set");
        s0 = n_start; cmd(8'h10);
        check(ry_by === 1'b1 && n_start == s0, "R13 stray 10h starts nothing", n_start, s0);
        cmd(8'h70); rd_exp(8'hC2, "R13 error sticky");

        // Program cancelled by another command (R7)
        cmd(8'h80); addr4(8'h00, 8'h00, 8'h05, 8'h00); dat(8'h5A);
        cmd(8'h90); adr(8'h00); rd_exp(8'h98, "R7 new command takes effect");
        s0 = n_start; cmd(8'h10);
        check(ry_by === 1'b1 && n_start == s0, "R7 cancelled program", n_start, s0);

        // Reset, ignored second reset, later reset (R11)
        cmd(8'hFF); cmd(8'hFF); busy_len(n);
        check(n == TRS - 2, "R11 second reset ignored", n, TRS - 2);
        cmd(8'h70); rd_exp(8'hC0, "R11 pass ready error cleared");
        cmd(8'hFF); busy_len(n);
        check(n == TRS, "R11 reset after ready acted on", n, TRS);

        // Only 70h/FFh while busy; ce_n high ignored (R3)
        cmd(8'h00); addr4(8'h10, 8'h00, 8'h23, 8'h01); cmd(8'h30);
        cmd(8'h90); ce_n = 1'b1; busy_len(n); ce_n = 1'b0;
        check(n == TR - 2, "R3 busy continues with ce_n high", n, TR - 2);
        rd_exp(8'hA1, "R3 90h ignored while busy");

        // Program fail, status while busy (R6, R3)
        arr_fail = 1'b1;
        cmd(8'h80); addr4(8'h20, 8'h00, 8'h24, 8'h01); dat(8'h11);
        cmd(8'h10); cmd(8'h70); rd_exp(8'h80, "R3 status during busy");
        busy_len(n); rd_exp(8'hC1, "R6 fail reported");
        arr_fail = 1'b0;

        // Erase (R14)
        cmd(8'h60); adr(8'h40); adr(8'h02); cmd(8'hD0); busy_len(n);
        check(n == TE, "R14 erase busy length", n, TE);
        check(last_kind == 2'd2 && last_row === 16'h0240, "R14 erase start", last_row, 16'h0240);
        cmd(8'h70); rd_exp(8'hC0, "R14 erase pass");

        // Write protect (R12)
        wp_n = 1'b0; cmd(8'h70); rd_exp(8'h40, "R12 protect bit");
        s0 = n_start;
        cmd(8'h80); addr4(8'h00, 8'h00, 8'h30, 8'h00); cmd(8'h10);
        check(ry_by === 1'b1 && n_start == s0, "R12 program inhibited", n_start, s0);
        wp_n = 1'b1;
        cmd(8'h60); adr(8'h80); adr(8'h00); cmd(8'hD0);
        check(ry_by === 1'b0, "R12 erase started", ry_by, 0);
        wp_n = 1'b0; @(negedge clk);
        check(ry_by === 1'b1, "R12 erase aborted", ry_by, 1);
        wp_n = 1'b1; cmd(8'h70); rd_exp(8'hC1, "R12 abort sets fail");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule